// File: doc/BRIEF.md
# Converter Control Mode Decoder

This block sits between a host's active-low converter control lines and the converter's sequencing logic. It watches chip select, write, read, sample/hold, calibrate and auto-zero on every clock and turns their edges into single-cycle commands. There are separate commands for a plain conversion start, a start with auto-zero, a start timed by the release of sample/hold, a result read and a calibration start. It also recognises a factory test combination and flags that combination when it could cause contention on the shared data bus.

Besides decoding, the block checks when a restart is legal. It keeps a short window of clocks after an auto-zero start in which a restart does no harm. A restart outside that window while the converter is still busy sets a sticky flag saying the correction factors are no longer trustworthy. The flag clears only when a calibration finishes. Calibration runs for a parameterised number of clocks, starts by itself out of reset, and cannot be interrupted. Start requests that arrive while it runs are dropped. Read accesses alternate between the high and low result byte, and every accepted conversion start returns the pointer to the high byte.

Top module: `convctl_mode_decoder`

## Requirements
- R1: A write-line rising edge seen while chip select was low in the previous cycle starts a conversion. The start is reported on `startAz` when `azN` is low at that edge and on `startNoAz` when `azN` is high. The pulse lasts one cycle, appears one clock after the edge, and at most one start or calibration command is high in any cycle.
- R2: A sample/hold rising edge seen while chip select was low in the previous cycle, with no write rising edge in the same cycle, produces a one-cycle `startSync` pulse one clock later.
- R3: A start accepted while `eoc` is low and no restart window is open sets `corrupt`. A start accepted while `eoc` is high leaves `corrupt` unchanged.
- R4: An accepted auto-zero write start opens a restart window of RESTART_WIN clocks (default 26). A restart on any of the next RESTART_WIN clock edges is legal even with `eoc` low. A restart on a later edge with `eoc` low sets `corrupt`. A start without auto-zero closes the window.
- R5: When chip select and calibrate first become low together, with read or sample/hold low, `calStart` pulses one clock later. `calBusy` is then high for exactly CAL_CYCLES sampled cycles, counting the cycle of the pulse (default 1399).
- R6: During reset every command output is low, `corrupt` and `testMode` are low, and `calBusy` is high. After reset is released, `calBusy` stays high for exactly CAL_CYCLES sampled cycles, as a power-up calibration.
- R7: While `calBusy` is high, conversion start requests and new calibration requests produce no pulse, and the running calibration ends on its original schedule.
- R8: `corrupt` stays set until a calibration completes, and it is low from the cycle in which `calBusy` falls.
- R9: When chip select and read first become low together with calibrate high, `readCmd` pulses one clock later. `readHigh` gives the byte served: 1 (high byte) for the first read after an accepted conversion start, then alternating 0, 1 and so on.
- R10: When chip select and calibrate first become low together with read and sample/hold both high, `testMode` is set one clock later and no calibration starts. While it is set, `testDriveEn` marks bus bits 2, 3, 5 and 6 (0x6C on an 8-bit bus). It clears one clock after chip select or calibrate goes high.
- R11: `busWarn` is high in the same cycle whenever `testMode` is set and `rdN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write, active low |
| rdN | input | 1 | Read, active low |
| shN | input | 1 | Sample/hold, active low |
| calN | input | 1 | Calibrate, active low |
| azN | input | 1 | Auto-zero enable, active low |
| eoc | input | 1 | End of conversion from the converter, high when idle |
| startNoAz | output | 1 | Start conversion without auto-zero |
| startAz | output | 1 | Start conversion with auto-zero |
| startSync | output | 1 | Start conversion on sample/hold release |
| readCmd | output | 1 | Read result command |
| readHigh | output | 1 | Byte served by the last read, 1 = high byte |
| calStart | output | 1 | Calibration start command |
| calBusy | output | 1 | Calibration in progress |
| corrupt | output | 1 | Correction factors invalid |
| testMode | output | 1 | Test combination active |
| testDriveEn | output | BUS_W | Bus bits turned into driven outputs in test mode |
| busWarn | output | 1 | Bus contention warning |

## Verification
Every command pulse, `readHigh`, `calBusy`, `corrupt` and `testMode` is registered. Each one is due one clock after the edge that samples its stimulus, so the bench drives inputs on the falling clock edge and reads outputs at the next falling edge. `busWarn` and `testDriveEn` follow their inputs combinationally and are read in the same cycle, a moment after the inputs change. Calibration length is measured by counting the falling-edge samples with `calBusy` high. The restart window is probed by placing the restart on the last edge inside the window and on the first edge past it.

// File: rtl/convctl_pkg.sv
package convctl_pkg;

  // Strobes from the decoder to the timing datapath, valid in the cycle of the edge
  typedef struct packed {
    logic convStart;  // an accepted conversion start of any kind
    logic useAz;      // that start was a write start with auto-zero
    logic calStart;   // an accepted calibration start
    logic readStrobe; // an accepted read access
  } ctlStrobe_t;

endpackage

// File: rtl/convctl_decode.sv
module convctl_decode
  import convctl_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             shN,
  input  logic             calN,
  input  logic             azN,
  input  logic             calBusy,
  output ctlStrobe_t       strobe,
  output logic             startNoAz,
  output logic             startAz,
  output logic             startSync,
  output logic             readCmd,
  output logic             calStart,
  output logic             testMode,
  output logic [BUS_W-1:0] testDriveEn,
  output logic             busWarn
);

  // Bus bits that become driven outputs in test mode
  localparam logic [BUS_W-1:0] TEST_MASK =
    (BUS_W'(1) << 2) | (BUS_W'(1) << 3) | (BUS_W'(1) << 5) | (BUS_W'(1) << 6);

  logic prevCsN, prevWrN, prevShN;
  logic prevCalCond, prevReadCond;

  logic wrRise, shRise, calCond, calEntry, testEntry;
  logic calReq, startReq, readCond, readReq, azReq, syncReq;

  always_comb begin
    wrRise    = !prevCsN && !prevWrN && wrN;
    shRise    = !prevCsN && !prevShN && shN;
    calCond   = !csN && !calN;
    calEntry  = calCond && !prevCalCond;
    testEntry = calEntry && rdN && shN;
    calReq    = calEntry && !(rdN && shN) && !calBusy;
    startReq  = (wrRise || shRise) && !calBusy && !calReq;
    azReq     = startReq && wrRise && !azN;
    syncReq   = startReq && !wrRise;
    readCond  = !csN && !rdN && calN;
    readReq   = readCond && !prevReadCond;

    strobe.convStart  = startReq;
    strobe.useAz      = azReq;
    strobe.calStart   = calReq;
    strobe.readStrobe = readReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCsN      <= 1'b1;
      prevWrN      <= 1'b1;
      prevShN      <= 1'b1;
      prevCalCond  <= 1'b0;
      prevReadCond <= 1'b0;
      startNoAz    <= 1'b0;
      startAz      <= 1'b0;
      startSync    <= 1'b0;
      readCmd      <= 1'b0;
      calStart     <= 1'b0;
      testMode     <= 1'b0;
    end else begin
      prevCsN      <= csN;
      prevWrN      <= wrN;
      prevShN      <= shN;
      prevCalCond  <= calCond;
      prevReadCond <= readCond;
      startNoAz    <= startReq && !azReq && !syncReq;
      startAz      <= azReq;
      startSync    <= syncReq;
      readCmd      <= readReq;
      calStart     <= calReq;
      if (!calCond)       testMode <= 1'b0;
      else if (testEntry) testMode <= 1'b1;
    end
  end

  for (genvar gi = 0; gi < BUS_W; gi++) begin : g_drive
    assign testDriveEn[gi] = testMode && TEST_MASK[gi];
  end

  assign busWarn = testMode && !rdN;

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startNoAz, startAz, startSync, calStart})) else $error("one command"); // R1
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startNoAz || startAz || startSync) |-> $past(!calBusy)) else $error("start in cal"); // R7
  AST_TEST_NO_CAL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testMode) |-> !calStart) else $error("cal in test"); // R10

endmodule

// File: rtl/convctl_timers.sv
module convctl_timers
  import convctl_pkg::*;
#(
  parameter int CAL_CYCLES  = 1399,
  parameter int RESTART_WIN = 26
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       eoc,
  output logic       calBusy,
  output logic       corrupt,
  output logic       readHigh
);

  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam int WW = $clog2(RESTART_WIN + 1);

  logic [CW-1:0] calCnt;
  logic [WW-1:0] winCnt;
  logic          bytePtr;
  logic          calDone, restartOk;

  assign calDone   = calBusy && (calCnt == '0) && !strobe.calStart;
  assign restartOk = eoc || (winCnt != '0);

  // Calibration length counter; reset loads one extra count for the power-up run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calBusy <= 1'b1;
      calCnt  <= CW'(CAL_CYCLES);
    end else if (strobe.calStart) begin
      calBusy <= 1'b1;
      calCnt  <= CW'(CAL_CYCLES - 1);
    end else if (calBusy) begin
      if (calCnt == '0) calBusy <= 1'b0;
      else              calCnt  <= calCnt - CW'(1);
    end
  end

  // Restart window after an auto-zero write start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  winCnt <= '0;
    else if (strobe.convStart)  winCnt <= strobe.useAz ? WW'(RESTART_WIN) : '0;
    else if (winCnt != '0)      winCnt <= winCnt - WW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 corrupt <= 1'b0;
    else if (calDone)                          corrupt <= 1'b0;
    else if (strobe.convStart && !restartOk)   corrupt <= 1'b1;
  end

  // High byte first after every accepted start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytePtr  <= 1'b1;
      readHigh <= 1'b0;
    end else if (strobe.convStart) begin
      bytePtr  <= 1'b1;
    end else if (strobe.readStrobe) begin
      readHigh <= bytePtr;
      bytePtr  <= !bytePtr;
    end
  end

  AST_CORRUPT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(corrupt) |-> $past(!eoc)) else $error("corrupt without busy converter"); // R3
  AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calBusy) |-> !corrupt) else $error("corrupt after cal"); // R8

endmodule

// File: rtl/convctl_mode_decoder.sv
module convctl_mode_decoder
  import convctl_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int CAL_CYCLES  = 1399,
  parameter int RESTART_WIN = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             shN,
  input  logic             calN,
  input  logic             azN,
  input  logic             eoc,
  output logic             startNoAz,
  output logic             startAz,
  output logic             startSync,
  output logic             readCmd,
  output logic             readHigh,
  output logic             calStart,
  output logic             calBusy,
  output logic             corrupt,
  output logic             testMode,
  output logic [BUS_W-1:0] testDriveEn,
  output logic             busWarn
);

  ctlStrobe_t strobe;

  convctl_decode #(.BUS_W(BUS_W)) u_decode (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .shN(shN),
    .calN(calN), .azN(azN), .calBusy(calBusy), .strobe(strobe),
    .startNoAz(startNoAz), .startAz(startAz), .startSync(startSync),
    .readCmd(readCmd), .calStart(calStart), .testMode(testMode),
    .testDriveEn(testDriveEn), .busWarn(busWarn)
  );

  convctl_timers #(.CAL_CYCLES(CAL_CYCLES), .RESTART_WIN(RESTART_WIN)) u_timers (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eoc(eoc),
    .calBusy(calBusy), .corrupt(corrupt), .readHigh(readHigh)
  );

  AST_CAL_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> calBusy) else $error("cal start without busy"); // R5

endmodule

// File: tb/tb_convctl_mode_decoder.sv
module tb_convctl_mode_decoder;

  localparam int CLK_PERIOD  = 10;
  localparam int BUS_W       = 8;
  localparam int CAL_CYCLES  = 1399;
  localparam int RESTART_WIN = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1, shN = 1'b1, calN = 1'b1, azN = 1'b1, eoc = 1'b1;
  logic startNoAz, startAz, startSync, readCmd, readHigh, calStart, calBusy, corrupt, testMode, busWarn;
  logic [BUS_W-1:0] testDriveEn;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  convctl_mode_decoder #(.BUS_W(BUS_W), .CAL_CYCLES(CAL_CYCLES), .RESTART_WIN(RESTART_WIN)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .shN(shN), .calN(calN),
    .azN(azN), .eoc(eoc), .startNoAz(startNoAz), .startAz(startAz), .startSync(startSync),
    .readCmd(readCmd), .readHigh(readHigh), .calStart(calStart), .calBusy(calBusy),
    .corrupt(corrupt), .testMode(testMode), .testDriveEn(testDriveEn), .busWarn(busWarn)
  );

  // inputs {csN,wrN,rdN,shN,calN,azN,eoc} _ expected {noAz,az,sync,rd,rdHigh,corrupt}
  localparam logic [12:0] VEC [0:13] = '{
    13'b1111111_000000, // idle
    13'b0011111_000000, // write low, no command yet
    13'b0111111_100000, // R1 write release, eoc high: legal (R3)
    13'b1111110_000000, // conversion running
    13'b0011110_000000,
    13'b0111110_100001, // R3 restart with eoc low, no window
    13'b1111111_000001, // R8 flag holds
    13'b0101111_000111, // R9 first read: high byte
    13'b1111111_000011,
    13'b0101111_000101, // R9 second read: low byte
    13'b1111111_000001,
    13'b0110111_000001, // sample/hold low
    13'b0111111_001001, // R2 sample/hold release
    13'b1111111_000001
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    int i;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 reset commands", {startNoAz, startAz, startSync, readCmd, calStart}, 0);
    chk("R6 reset busy", calBusy, 1);
    chk("R6 reset corrupt/test", {corrupt, testMode}, 0);
    rstN = 1'b1;
    cnt = 0;
    while (cnt < CAL_CYCLES + 10) begin
      tick();
      if (calBusy) cnt++; else break;
    end
    chk("R6 power-up calibration length", cnt, CAL_CYCLES);

    // Vector table: R1 R2 R3 R8 R9
    for (int v = 0; v < 14; v++) begin
      {csN, wrN, rdN, shN, calN, azN, eoc} = VEC[v][12:6];
      tick();
      chk($sformatf("R1 startNoAz vec %0d", v), startNoAz, VEC[v][5]);
      chk($sformatf("R1 startAz vec %0d", v), startAz, VEC[v][4]);
      chk($sformatf("R2 startSync vec %0d", v), startSync, VEC[v][3]);
      chk($sformatf("R9 readCmd vec %0d", v), readCmd, VEC[v][2]);
      chk($sformatf("R9 readHigh vec %0d", v), readHigh, VEC[v][1]);
      chk($sformatf("R3 corrupt vec %0d", v), corrupt, VEC[v][0]);
    end

    // R5 calibration start, R7 ignored requests, R8 clearing
    {csN, calN, rdN} = 3'b000;
    tick();
    chk("R5 calStart pulse", calStart, 1);
    chk("R5 busy after start", calBusy, 1);
    chk("R8 corrupt held during cal", corrupt, 1);
    cnt = 1;
    i = 1;
    {csN, calN, rdN} = 3'b111;
    while (calBusy && i < CAL_CYCLES + 10) begin
      case (i)
        3: {csN, calN, rdN} = 3'b000;
        5: {csN, calN, rdN} = 3'b111;
        6: {csN, wrN, eoc} = 3'b000;
        7: wrN = 1'b1;
        8: csN = 1'b1;
        default: ;
      endcase
      tick();
      i++;
      if (i == 4) chk("R7 cal request ignored", calStart, 0);
      if (i == 8) chk("R7 start ignored", {startNoAz, startAz, startSync}, 0);
      if (calBusy) cnt++;
    end
    chk("R5 calibration length", cnt, CAL_CYCLES);
    chk("R8 corrupt cleared", corrupt, 0);
    eoc = 1'b1;
    tick();

    // R4 restart window
    {csN, wrN, azN} = 3'b000;
    tick();
    wrN = 1'b1;
    tick();
    chk("R4 first auto-zero start", startAz, 1);
    {csN, eoc} = 2'b10;
    repeat (RESTART_WIN - 2) tick();
    {csN, wrN} = 2'b00;
    tick();
    wrN = 1'b1;
    tick();
    chk("R4 restart on last window edge", startAz, 1);
    chk("R4 no corrupt inside window", corrupt, 0);
    csN = 1'b1;
    repeat (RESTART_WIN - 1) tick();
    {csN, wrN} = 2'b00;
    tick();
    wrN = 1'b1;
    tick();
    chk("R4 restart past window", startAz, 1);
    chk("R4 corrupt past window", corrupt, 1);
    {csN, azN, eoc} = 3'b111;
    tick();

    // R10 R11 test mode
    {csN, calN, rdN, shN} = 4'b0011;
    tick();
    chk("R10 testMode set", testMode, 1);
    chk("R10 no calStart", calStart, 0);
    chk("R10 drive mask", testDriveEn, 8'h6C);
    chk("R11 no warn with read high", busWarn, 0);
    rdN = 1'b0;
    #1;
    chk("R11 warn with read low", busWarn, 1);
    tick();
    chk("R9 no read in test mode", readCmd, 0);
    {calN, rdN} = 2'b11;
    tick();
    chk("R10 testMode cleared", testMode, 0);
    chk("R10 drive cleared", testDriveEn, 0);
    chk("R11 warn cleared", busWarn, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule